// File: doc/BRIEF.md
# Gradual LED Dimming Sequencer

This block produces the 5-bit drive code for an external LED current DAC. Software can load a code directly, which takes effect on the next clock edge. It can also program a rising target and a falling target and then start a slow staircase toward one of them. A write to the timing register picks the step period and starts the staircase. The code then moves one step per period until it reaches the chosen target.

The step period is built from two stages. A base tick is divided from the converter clock by a fixed ratio (8192 by default). The programmed 5-bit timing value then stretches that tick by a further factor of value+1. A registered lookup turns the current code into a fixed-point output-current percentage. The code-to-current curve is steep and roughly logarithmic, so a linear walk through the codes reads as smooth dimming. A shutdown input forces the light off and cancels any ramp in progress.

Top module: `led_dim_seq`

## Requirements
- R1: After reset, `level_code` is 0, `busy` is 0 and `pct_q` is 0.
- R2: A pulse on `wr_direct` with shutdown low loads `wr_data[4:0]` into `level_code` at the next edge. Bits 7:5 are ignored. `busy` is low after that edge, which cancels any ramp in progress.
- R3: `wr_up` and `wr_down` store `wr_data[4:0]` as the rising and falling targets (bits 7:5 ignored). The stored values are used by the next launch.
- R4: A pulse on `wr_timing` stores `wr_data[4:0]` as the timing value T and launches a ramp. If the rising target is above the current code, the code ramps up to it. Otherwise, if the falling target is below the current code, the code ramps down to it. Otherwise the launch is ignored: `busy` stays low and the code does not change.
- R5: During a ramp, each step changes the code by exactly one toward the target. `busy` is high from the launch edge until the edge on which the code reaches the target, and goes low on that edge. While `busy` is low and no direct write or shutdown occurs, the code holds.
- R6: The first step lands BASE_DIV*(T+1) clock edges after the launch edge. Each later step follows the previous one by the same number of edges.
- R7: While `sdn` is high, `level_code` is 0 from the next edge and `busy` is low. Direct writes and launches have no effect on the code. After `sdn` falls, the code stays 0 until a new write.
- R8: One edge after `level_code` takes a value, `pct_q` holds that code's output current in hundredths of a percent. Code 0 maps to 0, code 31 maps to 10000, and the curve between them is monotonic, for example code 8 maps to 140 and code 24 maps to 2748.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter-derived system clock |
| rst | input | 1 | Synchronous active-high reset |
| sdn | input | 1 | Shutdown flag; forces the code to zero |
| wr_direct | input | 1 | Strobe: load the code directly |
| wr_up | input | 1 | Strobe: store the rising target |
| wr_down | input | 1 | Strobe: store the falling target |
| wr_timing | input | 1 | Strobe: store the timing value and launch a ramp |
| wr_data | input | 8 | Register byte; only bits 4:0 are used |
| level_code | output | 5 | Current drive code for the DAC |
| busy | output | 1 | High while a ramp is moving |
| pct_q | output | 14 | Output current in hundredths of a percent |

## Verification
The bench runs a small base divide ratio. It measures the exact edge on which each ramp step lands for several timing values, so an off-by-one in either divider stage shows up as a step one base period early or late. It covers launches where both targets fail their comparisons, and launches where the rising target wins even though a lower falling target is also valid. A design that swapped the priority, or started a ramp it should have ignored, would move the code. A direct write in the middle of a ramp, and a shutdown during a ramp while writes keep arriving, are both checked. A design that let a pending step through would show a code that drifts afterwards. The direct-load path is swept over all 256 byte values against the percentage curve.

// File: rtl/dim_pkg.sv
package dim_pkg;
  localparam int CODE_W = 5;
  localparam int PCT_W  = 14;

  typedef enum logic {DIR_UP = 1'b0, DIR_DOWN = 1'b1} ramp_dir_t;

  // Output current in hundredths of a percent for each drive code.
  function automatic logic [PCT_W-1:0] code_to_pct(input logic [CODE_W-1:0] c);
    logic [PCT_W-1:0] v;
    case (c)
      5'd0:  v = 14'd0;     5'd1:  v = 14'd42;    5'd2:  v = 14'd49;
      5'd3:  v = 14'd57;    5'd4:  v = 14'd72;    5'd5:  v = 14'd87;
      5'd6:  v = 14'd102;   5'd7:  v = 14'd117;   5'd8:  v = 14'd140;
      5'd9:  v = 14'd170;   5'd10: v = 14'd200;   5'd11: v = 14'd242;
      5'd12: v = 14'd299;   5'd13: v = 14'd363;   5'd14: v = 14'd435;
      5'd15: v = 14'd522;   5'd16: v = 14'd624;   5'd17: v = 14'd752;
      5'd18: v = 14'd911;   5'd19: v = 14'd1092;  5'd20: v = 14'd1308;
      5'd21: v = 14'd1580;  5'd22: v = 14'd1897;  5'd23: v = 14'd2286;
      5'd24: v = 14'd2748;  5'd25: v = 14'd3303;  5'd26: v = 14'd3972;
      5'd27: v = 14'd4772;  5'd28: v = 14'd5747;  5'd29: v = 14'd6918;
      5'd30: v = 14'd8320;  default: v = 14'd10000;
    endcase
    return v;
  endfunction
endpackage

// File: rtl/dim_prescaler.sv
module dim_prescaler #(
  parameter int BASE_DIV = 8192
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  output logic base_tick
);
  localparam int PW = (BASE_DIV > 2) ? $clog2(BASE_DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(BASE_DIV - 1);

  logic [PW-1:0] pre_q;

  assign base_tick = (pre_q == LAST);

  generate
    if ((BASE_DIV & (BASE_DIV - 1)) == 0) begin : g_pow2
      // Ratio is a power of two: the counter wraps on its own.
      always_ff @(posedge clk) begin
        if (rst || clear) pre_q <= '0;
        else              pre_q <= pre_q + 1'b1;
      end
    end else begin : g_any
      always_ff @(posedge clk) begin
        if (rst || clear)   pre_q <= '0;
        else if (base_tick) pre_q <= '0;
        else                pre_q <= pre_q + 1'b1;
      end
    end
  endgenerate
endmodule

// File: rtl/dim_step_timer.sv
module dim_step_timer #(
  parameter int TIM_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             enable,
  input  logic             base_tick,
  input  logic [TIM_W-1:0] period,
  output logic             step
);
  logic [TIM_W-1:0] cnt_q;

  assign step = enable && base_tick && (cnt_q == period);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      cnt_q <= '0;
    end else if (enable && base_tick) begin
      if (cnt_q == period) cnt_q <= '0;
      else                 cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/dim_ramp_ctrl.sv
module dim_ramp_ctrl
  import dim_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sdn,
  input  logic              wr_direct,
  input  logic              wr_up,
  input  logic              wr_down,
  input  logic              wr_timing,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              step,
  output logic [CODE_W-1:0] code,
  output logic              busy,
  output logic [CODE_W-1:0] tim,
  output logic              launch
);
  logic [CODE_W-1:0] up_q, dn_q, tgt_q, code_q, tim_q, nxt_code, wval;
  logic              busy_q, go_up, go_dn;
  ramp_dir_t         dir_q;
  logic              unused_hi;

  assign wval      = wr_data[CODE_W-1:0];
  assign unused_hi = ^wr_data[DATA_W-1:CODE_W];

  assign go_up  = wr_timing && !sdn && !wr_direct && (up_q > code_q);
  assign go_dn  = wr_timing && !sdn && !wr_direct && !(up_q > code_q) && (dn_q < code_q);
  assign launch = go_up || go_dn;

  assign nxt_code = (dir_q == DIR_UP) ? code_q + 1'b1 : code_q - 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      up_q   <= '0;
      dn_q   <= '0;
      tim_q  <= '0;
      tgt_q  <= '0;
      code_q <= '0;
      busy_q <= 1'b0;
      dir_q  <= DIR_UP;
    end else begin
      if (wr_up)     up_q  <= wval;
      if (wr_down)   dn_q  <= wval;
      if (wr_timing) tim_q <= wval;

      if (sdn) begin
        code_q <= '0;
        busy_q <= 1'b0;
      end else if (wr_direct) begin
        code_q <= wval;
        busy_q <= 1'b0;
      end else if (go_up) begin
        tgt_q  <= up_q;
        dir_q  <= DIR_UP;
        busy_q <= 1'b1;
      end else if (go_dn) begin
        tgt_q  <= dn_q;
        dir_q  <= DIR_DOWN;
        busy_q <= 1'b1;
      end else if (busy_q && step) begin
        code_q <= nxt_code;
        busy_q <= (nxt_code != tgt_q);
      end
    end
  end

  assign code = code_q;
  assign busy = busy_q;
  assign tim  = tim_q;
endmodule

// File: rtl/dim_pct_map.sv
module dim_pct_map
  import dim_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] code,
  output logic [PCT_W-1:0]  pct
);
  // Registered read of a constant table; maps onto a ROM.
  always_ff @(posedge clk) begin
    if (rst) pct <= '0;
    else     pct <= code_to_pct(code);
  end
endmodule

// File: rtl/led_dim_seq.sv
module led_dim_seq
  import dim_pkg::*;
#(
  parameter int BASE_DIV = 8192,
  parameter int DATA_W   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sdn,
  input  logic              wr_direct,
  input  logic              wr_up,
  input  logic              wr_down,
  input  logic              wr_timing,
  input  logic [DATA_W-1:0] wr_data,
  output logic [CODE_W-1:0] level_code,
  output logic              busy,
  output logic [PCT_W-1:0]  pct_q
);
  logic              base_tick, step, launch;
  logic [CODE_W-1:0] tim;

  dim_prescaler #(.BASE_DIV(BASE_DIV)) u_pre (
    .clk(clk), .rst(rst), .clear(launch), .base_tick(base_tick)
  );

  dim_step_timer #(.TIM_W(CODE_W)) u_tmr (
    .clk(clk), .rst(rst), .clear(launch), .enable(busy),
    .base_tick(base_tick), .period(tim), .step(step)
  );

  dim_ramp_ctrl #(.DATA_W(DATA_W)) u_ctl (
    .clk(clk), .rst(rst), .sdn(sdn), .wr_direct(wr_direct), .wr_up(wr_up),
    .wr_down(wr_down), .wr_timing(wr_timing), .wr_data(wr_data), .step(step),
    .code(level_code), .busy(busy), .tim(tim), .launch(launch)
  );

  dim_pct_map u_map (
    .clk(clk), .rst(rst), .code(level_code), .pct(pct_q)
  );
endmodule

// File: rtl/led_dim_seq_chk.sv
module led_dim_seq_chk
  import dim_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              sdn,
  input logic              wr_direct,
  input logic [DATA_W-1:0] wr_data,
  input logic [CODE_W-1:0] level_code,
  input logic              busy,
  input logic [PCT_W-1:0]  pct_q
);
  p_sdn_zero_r7: assert property (@(posedge clk) disable iff (rst)
    sdn |=> (level_code == '0) && !busy);

  p_direct_load_r2: assert property (@(posedge clk) disable iff (rst)
    (wr_direct && !sdn) |=> (level_code == $past(wr_data[CODE_W-1:0])) && !busy);

  p_unit_step_r5: assert property (@(posedge clk) disable iff (rst)
    (!wr_direct && !sdn) |=> ((level_code == $past(level_code)) ||
      ({1'b0, level_code} == {1'b0, $past(level_code)} + 6'd1) ||
      ({1'b0, level_code} + 6'd1 == {1'b0, $past(level_code)})));

  p_idle_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (!busy && !wr_direct && !sdn) |=> $stable(level_code));

  p_pct_low_r8: assert property (@(posedge clk) disable iff (rst)
    (level_code == '0) |=> (pct_q == '0));

  p_pct_full_r8: assert property (@(posedge clk) disable iff (rst)
    (level_code == '1) |=> (pct_q == PCT_W'(10000)));
endmodule

bind led_dim_seq led_dim_seq_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .sdn(sdn), .wr_direct(wr_direct), .wr_data(wr_data),
  .level_code(level_code), .busy(busy), .pct_q(pct_q)
);

// File: tb/led_dim_seq_test.sv
module led_dim_seq_test;
  localparam int BD = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sdn = 1'b0;
  logic        wr_direct = 1'b0, wr_up = 1'b0, wr_down = 1'b0, wr_timing = 1'b0;
  logic [7:0]  wr_data = '0;
  logic [4:0]  level_code;
  logic        busy;
  logic [13:0] pct_q;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  led_dim_seq #(.BASE_DIV(BD)) uut (
    .clk(clk), .rst(rst), .sdn(sdn), .wr_direct(wr_direct), .wr_up(wr_up),
    .wr_down(wr_down), .wr_timing(wr_timing), .wr_data(wr_data),
    .level_code(level_code), .busy(busy), .pct_q(pct_q)
  );

  always #5 clk = ~clk;

  function automatic int exp_pct(input int c);
    int t[32] = '{0, 42, 49, 57, 72, 87, 102, 117, 140, 170, 200, 242, 299, 363,
                  435, 522, 624, 752, 911, 1092, 1308, 1580, 1897, 2286, 2748,
                  3303, 3972, 4772, 5747, 6918, 8320, 10000};
    return t[c & 31];
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // sel: 0 direct, 1 up, 2 down, 3 timing
  task automatic wr(input int sel, input logic [7:0] d);
    @(negedge clk);
    wr_data   = d;
    wr_direct = (sel == 0);
    wr_up     = (sel == 1);
    wr_down   = (sel == 2);
    wr_timing = (sel == 3);
    @(negedge clk);
    wr_direct = 1'b0; wr_up = 1'b0; wr_down = 1'b0; wr_timing = 1'b0;
  endtask

  task automatic do_ramp(input int start, input logic [7:0] up, input logic [7:0] dn,
                         input logic [7:0] tb);
    int u = up & 31;
    int d = dn & 31;
    int t = tb & 31;
    int p = BD * (t + 1);
    int tgt;
    int prev;
    bit go;
    wr(0, 8'(start));
    wr(1, up);
    wr(2, dn);
    if (u > start)      begin go = 1; tgt = u; end
    else if (d < start) begin go = 1; tgt = d; end
    else                begin go = 0; tgt = start; end
    wr(3, tb);
    prev = start;
    if (!go) begin
      chk(busy == 1'b0, "R4 ignored launch busy", busy, 0);
      repeat (3 * p) @(negedge clk);
      chk(level_code == 5'(start), "R4 ignored launch code", level_code, start);
      return;
    end
    chk(busy == 1'b1, "R4 launch busy", busy, 1);
    while (prev != tgt) begin
      int nxt = (tgt > prev) ? prev + 1 : prev - 1;
      @(negedge clk);
      chk(pct_q == 14'(exp_pct(prev)), "R8 pct during ramp", pct_q, exp_pct(prev));
      repeat (p - 2) @(negedge clk);
      chk(level_code == 5'(prev) && busy, "R6 no early step", level_code, prev);
      @(negedge clk);
      chk(level_code == 5'(nxt), "R5 R6 step on time", level_code, nxt);
      prev = nxt;
    end
    chk(busy == 1'b0, "R5 busy clears at target", busy, 0);
    @(negedge clk);
    chk(pct_q == 14'(exp_pct(tgt)), "R8 pct at target", pct_q, exp_pct(tgt));
    repeat (2 * p) @(negedge clk);
    chk(level_code == 5'(tgt) && !busy, "R5 hold after target", level_code, tgt);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(level_code == 5'd0, "R1 reset code", level_code, 0);
    chk(busy == 1'b0, "R1 reset busy", busy, 0);
    chk(pct_q == 14'd0, "R1 reset pct", pct_q, 0);

    // R2 and R8: every byte through the direct path
    for (int d = 0; d < 256; d++) begin
      wr(0, 8'(d));
      chk(level_code == 5'(d & 31) && !busy, "R2 direct load", level_code, d & 31);
      @(negedge clk);
      chk(pct_q == 14'(exp_pct(d)), "R8 pct map", pct_q, exp_pct(d));
    end

    // R3 R4 R5 R6 ramps
    do_ramp(0, 8'd31, 8'd0, 8'd0);
    do_ramp(31, 8'd0, 8'd0, 8'd1);
    do_ramp(10, 8'd10, 8'd10, 8'd0);
    do_ramp(5, 8'd20, 8'd2, 8'd2);
    do_ramp(20, 8'd3, 8'd25, 8'd0);
    do_ramp(7, 8'd7, 8'd7, 8'd3);
    do_ramp(2, 8'hE9, 8'hE0, 8'hE1);
    do_ramp(16, 8'd16, 8'hF4, 8'd0);
    for (int s = 0; s < 32; s += 7) do_ramp(s, 8'(s + 3), 8'd0, 8'd0);

    // R2: direct write cancels a ramp
    wr(0, 8'd0); wr(1, 8'd31); wr(3, 8'd0);
    repeat (2 * BD + 1) @(negedge clk);
    wr(0, 8'hD3);
    chk(level_code == 5'd19 && !busy, "R2 cancel ramp", level_code, 19);
    repeat (4 * BD) @(negedge clk);
    chk(level_code == 5'd19 && !busy, "R2 cancel holds", level_code, 19);

    // R7: shutdown during a ramp
    wr(0, 8'd3); wr(1, 8'd31); wr(3, 8'd0);
    repeat (BD + 2) @(negedge clk);
    sdn = 1'b1;
    @(negedge clk);
    chk(level_code == 5'd0 && !busy, "R7 shutdown forces zero", level_code, 0);
    wr(0, 8'd9);
    chk(level_code == 5'd0, "R7 direct ignored in shutdown", level_code, 0);
    wr(1, 8'd20); wr(3, 8'd0);
    chk(busy == 1'b0, "R7 launch ignored in shutdown", busy, 0);
    repeat (3 * BD) @(negedge clk);
    chk(level_code == 5'd0, "R7 code held in shutdown", level_code, 0);
    chk(pct_q == 14'd0, "R8 pct zero in shutdown", pct_q, 0);
    sdn = 1'b0;
    repeat (2) @(negedge clk);
    chk(level_code == 5'd0 && !busy, "R7 zero after release", level_code, 0);
    wr(3, 8'd0);
    chk(busy == 1'b1, "R3 target kept through shutdown", busy, 1);
    wr(0, 8'd0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule